// File: doc/BRIEF.md
# PWM fault shutdown controller

This block sits between a three-phase PWM timing unit and the six gate-drive outputs. It puts the PWM into a safe stopped state when either of two sources asks for it. One source is an active-low external trip input. The other is a software strobe, made by any write to a one-bit shutdown register. When a shutdown happens, the block does four things: it drives every output to its OFF level, holds back the sync pulse, tells the timing unit to stop, and raises a one-clock trip interrupt. The polarity input sets the OFF level.

The trip input acts on the outputs at once, through an asynchronous set, and does not wait for a clock edge. Software re-arms the block by writing all four timing registers, in any order, after the shutdown. The four registers are the period register and the three duty registers. The trip input must also be high again. Once re-armed, the timing unit restarts, but the outputs stay OFF until the next sync boundary. From then on the gated waveform passes through. A status flag reports whether the most recent shutdown came from software, and reading it clears it. A second status bit reports the synchronized trip level.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: While trip_ni is low, all six pwm_o bits are at the OFF level. This holds from the moment trip_ni falls, before any clock edge.
- R2: The OFF level is 0 when polarity_i=1 and 1 when polarity_i=0. When the PWM is enabled, pwm_o equals pwm_raw_i if polarity_i=1 and ~pwm_raw_i if polarity_i=0.
- R3: sync_o equals sync_raw_i while timing_run_o=1, and is 0 while timing_run_o=0.
- R4: Each shutdown event raises irq_o for exactly one clock cycle. An event is a trip_ni falling edge seen by the synchronizer, or a software strobe.
- R5: A write (wr_i=1) to address 4 causes a shutdown, whatever the data: timing_run_o drops at the next edge and all outputs go OFF.
- R6: sw_flag_o is set by a write to address 4. It is cleared by a read (rd_i=1) of address 4, and by a hardware trip event. If a set and a clear fall in the same cycle, the set wins.
- R7: A shutdown ends only after writes to addresses 0, 1, 2 and 3, in any order, made after the latest shutdown event, and with the synchronized trip level high. With any of the four writes missing, the block stays shut down.
- R8: After re-arm, timing_run_o is 1, but the outputs stay OFF until a cycle with sync_raw_i=1. From the following cycle, the outputs follow R2.
- R9: trip_lvl_o reflects trip_ni after two clock cycles of synchronization.
- R10: After reset, with trip_ni high: timing_run_o=1, irq_o=0, sw_flag_o=0, trip_lvl_o=1, and the outputs follow R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trip_ni | input | 1 | Active-low external trip |
| polarity_i | input | 1 | 1: outputs active high, 0: outputs active low |
| pwm_raw_i | input | 6 | Active-high switch commands from the timing unit |
| sync_raw_i | input | 1 | Sync pulse from the timing unit |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address: 0 period, 1..3 duty, 4 shutdown |
| pwm_o | output | 6 | Gated gate-drive outputs |
| sync_o | output | 1 | Gated sync pulse, which also serves as the sync interrupt |
| timing_run_o | output | 1 | Run enable for the three-phase timing unit |
| irq_o | output | 1 | One-cycle trip interrupt |
| sw_flag_o | output | 1 | The last shutdown came from software |
| trip_lvl_o | output | 1 | Synchronized trip_ni level |

## Verification
The gating is swept over all 64 raw output patterns under both polarities, in the running state and in the stopped state. This separates inversion errors from gating errors.

Re-arm is tried in several ways:
- with one register write missing;
- with all four writes made while the trip is still low;
- with the writes made before the shutdown, which must not count;
- with the writes in reverse order.

Together these separate a correct write mask from a counter or a sticky mask. The asynchronous trip is checked between clock edges, to tell a true asynchronous path from a synchronized one. The software flag is checked to clear on a read and on a hardware trip.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned N_TMR    = 4;  // period + three duty registers
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SWT    = 3'd4;
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_ni,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sff_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sff_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      sff_q  <= {sff_q[STAGES-2:0], trip_ni};
      prev_q <= sff_q[STAGES-1];
    end
  end

  assign level_o = sff_q[STAGES-1];
  assign fall_o  = prev_q & ~sff_q[STAGES-1];
endmodule

// File: rtl/pwm_rearm_mask.sv
module pwm_rearm_mask
  import pwm_trip_pkg::*;
#(
  parameter int unsigned NREG = N_TMR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              full_o
);
  logic [NREG-1:0] mask_q;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_PERIOD + ADDR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mask_q[i] <= 1'b0;
      else if (clr_i)                        mask_q[i] <= 1'b0;
      else if (wr_i && addr_i == MY_ADDR)    mask_q[i] <= 1'b1;
    end
  end

  assign full_o = &mask_q;
endmodule

// File: rtl/pwm_out_gate.sv
module pwm_out_gate #(
  parameter int unsigned N_OUT = 6
) (
  input  logic             off_i,
  input  logic             polarity_i,
  input  logic [N_OUT-1:0] raw_i,
  output logic [N_OUT-1:0] pwm_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    assign pwm_o[i] = (raw_i[i] & ~off_i) ^ ~polarity_i;
  end
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int unsigned N_OUT       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trip_ni,
  input  logic              polarity_i,
  input  logic [N_OUT-1:0]  pwm_raw_i,
  input  logic              sync_raw_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              sync_o,
  output logic              timing_run_o,
  output logic              irq_o,
  output logic              sw_flag_o,
  output logic              trip_lvl_o
);
  logic hw_fall, sw_evt, evt, mask_full, rearm;
  logic shut_q, pend_q, irq_q, flag_q;

  pwm_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .trip_ni,
    .level_o(trip_lvl_o), .fall_o(hw_fall)
  );

  assign sw_evt = wr_i && addr_i == ADDR_SWT;
  assign evt    = sw_evt | hw_fall;

  pwm_rearm_mask #(.NREG(N_TMR)) u_mask (
    .clk_i, .rst_ni, .clr_i(evt | rearm), .wr_i, .addr_i, .full_o(mask_full)
  );

  assign rearm = shut_q & mask_full & trip_lvl_o & ~evt;

  // trip pin sets the shutdown state asynchronously
  always_ff @(posedge clk_i or negedge rst_ni or negedge trip_ni) begin
    if (!rst_ni)       shut_q <= 1'b0;
    else if (!trip_ni) shut_q <= 1'b1;
    else if (evt)      shut_q <= 1'b1;
    else if (rearm)    shut_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= evt;
      if (evt)                        pend_q <= 1'b0;
      else if (rearm)                 pend_q <= 1'b1;
      else if (sync_raw_i && !shut_q) pend_q <= 1'b0;
      if (sw_evt)                                  flag_q <= 1'b1;
      else if (hw_fall || (rd_i && addr_i == ADDR_SWT)) flag_q <= 1'b0;
    end
  end

  pwm_out_gate #(.N_OUT(N_OUT)) u_gate (
    .off_i(shut_q | pend_q), .polarity_i, .raw_i(pwm_raw_i), .pwm_o
  );

  assign sync_o       = sync_raw_i & ~shut_q;
  assign timing_run_o = ~shut_q;
  assign irq_o        = irq_q;
  assign sw_flag_o    = flag_q;
endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk #(
  parameter int unsigned N_OUT = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trip_ni,
  input logic             polarity_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [2:0]       addr_i,
  input logic [N_OUT-1:0] pwm_o,
  input logic             sync_o,
  input logic             timing_run_o,
  input logic             irq_o,
  input logic             sw_flag_o
);
  a_r1_trip_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> pwm_o == {N_OUT{~polarity_i}});
  a_r3_no_sync_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timing_run_o |-> !sync_o);
  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r5_sw_write_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd4) |=> !timing_run_o);
  a_r6_sw_write_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd4) |=> sw_flag_o);
  a_r6_read_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == 3'd4) |=> !sw_flag_o);
  a_r8_off_at_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timing_run_o) |-> pwm_o == {N_OUT{~polarity_i}});
endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trip_ni(trip_ni), .polarity_i(polarity_i),
  .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .pwm_o(pwm_o), .sync_o(sync_o),
  .timing_run_o(timing_run_o), .irq_o(irq_o), .sw_flag_o(sw_flag_o)
);

// File: tb/pwm_trip_ctrl_test.sv
`timescale 1ns/1ps
module pwm_trip_ctrl_test;
  logic clk = 0, rst_n = 0, trip_n = 1, pol = 1, sync_raw = 0, wr = 0, rd = 0;
  logic [5:0] raw = 6'b101010;
  logic [2:0] addr = 0;
  logic [5:0] pwm;
  logic sync_o, run, irq, flag, lvl;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #4 clk = ~clk;

  pwm_trip_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .trip_ni(trip_n), .polarity_i(pol),
    .pwm_raw_i(raw), .sync_raw_i(sync_raw), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .pwm_o(pwm), .sync_o(sync_o), .timing_run_o(run), .irq_o(irq),
    .sw_flag_o(flag), .trip_lvl_o(lvl)
  );

  always @(posedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] a);
    @(posedge clk); #1; wr = 1; addr = a;
    @(posedge clk); #1; wr = 0; addr = 0;
  endtask

  function automatic logic [5:0] exp_pwm(input logic off, input logic p, input logic [5:0] r);
    return off ? (p ? 6'h00 : 6'h3f) : (p ? r : ~r);
  endfunction

  task automatic sweep(input logic off, input string req);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 64; r++) begin
        pol = p[0]; raw = r[5:0]; #1;
        chk(req, pwm, exp_pwm(off, p[0], r[5:0]));
      end
    pol = 1; raw = 6'b101010;
  endtask

  task automatic sync_pulse;
    @(posedge clk); #1; sync_raw = 1; #1;
    chk("R3 sync passes when running", sync_o, 1);
    @(posedge clk); #1; sync_raw = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    step(2); rst_n = 1; step(2);
    chk("R10 run", run, 1);
    chk("R10 irq", irq, 0);
    chk("R10 flag", flag, 0);
    chk("R10 lvl", lvl, 1);
    chk("R10 pwm", pwm, 6'b101010);
    sweep(0, "R2 running");
    sync_raw = 1; #1; chk("R3 running sync", sync_o, 1); sync_raw = 0;

    // software shutdown
    c0 = irq_cnt;
    wr_reg(3'd4);
    chk("R5 run low", run, 0);
    chk("R5 pwm off", pwm, 6'h00);
    chk("R6 flag set", flag, 1);
    step(4);
    chk("R4 one irq sw", irq_cnt - c0, 1);
    sweep(1, "R2 stopped");
    sync_raw = 1; #1; chk("R3 sync blocked", sync_o, 0); sync_raw = 0;

    // partial rearm
    wr_reg(3'd0); wr_reg(3'd1); wr_reg(3'd2); step(5);
    chk("R7 three writes", run, 0);
    wr_reg(3'd3); step(3);
    chk("R7 rearmed", run, 1);
    chk("R8 pending off", pwm, 6'h00);
    sync_pulse();
    chk("R8 follows after sync", pwm, 6'b101010);

    // hardware trip, asynchronous
    c0 = irq_cnt;
    @(negedge clk); #1; trip_n = 0; #1;
    chk("R1 async off", pwm, 6'h00);
    step(5);
    chk("R9 lvl low", lvl, 0);
    chk("R4 one irq hw", irq_cnt - c0, 1);
    chk("R6 hw clears flag", flag, 0);
    chk("R1 run low", run, 0);
    wr_reg(3'd0); wr_reg(3'd1); wr_reg(3'd2); wr_reg(3'd3); step(4);
    chk("R7 trip still low", run, 0);
    trip_n = 1; step(6);
    chk("R9 lvl high", lvl, 1);
    chk("R7 rearm after release", run, 1);
    chk("R8 still off", pwm, 6'h00);
    sync_pulse();
    chk("R8 follows", pwm, 6'b101010);

    // flag read clear; stale writes don't count
    wr_reg(3'd0); wr_reg(3'd1); wr_reg(3'd2); wr_reg(3'd3);
    wr_reg(3'd4);
    chk("R6 flag set again", flag, 1);
    @(posedge clk); #1; rd = 1; addr = 3'd4;
    @(posedge clk); #1; rd = 0; addr = 0;
    chk("R6 read clears", flag, 0);
    step(5);
    chk("R7 stale writes ignored", run, 0);
    wr_reg(3'd3); wr_reg(3'd2); wr_reg(3'd1); wr_reg(3'd0); step(3);
    chk("R7 reverse order", run, 1);
    sync_pulse();
    pol = 0; #1;
    chk("R2 inverted after restart", pwm, 6'b010101);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule